// File: doc/BRIEF.md
# Scatter-Gather Descriptor Chain Walker

This block follows a linked run of 8-byte region descriptors in memory for one storage port. A command block supplies the byte address of the first descriptor and the byte count the whole command is expected to move. A one-cycle `start` pulse passes both values in. The walker then fetches each descriptor as two 32-bit words over a single-outstanding memory read port. It hands the region's address, length, direction and raw flag byte to an external data mover. It waits for the mover's completion strobe and then steps to the next descriptor, 8 bytes further on.

The walk stops at the descriptor whose flags mark it as the last of the chain. The walker then compares the sum of all issued lengths with the expected count and raises a shortfall or an excess bit in a response byte. The walk aborts with an error bit in three cases: a descriptor has a zero length field, since that would stand for a full 64 KiB region; a length exceeds the permitted segment size; or the descriptor budget runs out before any entry carries the last flag. A command-packet entry counts toward the sum like any data entry.

Top module: `sgw_walker`

## Requirements
- R1: After an accepted start, the first read goes to `first_ptr`, the second to `first_ptr`+4, and the next descriptor's first read to `first_ptr`+8. `mem_rd_req` is a one-cycle pulse with at most one read outstanding.
- R2: The first descriptor word is the 32-bit region address. The second word carries the length in bits 15:0, a reserved byte in bits 23:16 and the flag byte in bits 31:24. A transfer request presents that address and length, `xfer_write` equal to flag bit 5, and the whole flag byte on `xfer_flags`.
- R3: `xfer_valid` stays high with unchanged address, length and flags until `xfer_done` is seen, and no memory read is issued while a transfer is pending.
- R4: After the transfer of the entry with flag bit 7 set, `done` pulses for one cycle with `busy` low. When the sum equals the total, `resp` is 0x01 (bit 0 marks normal completion).
- R5: If the summed lengths are below the total, `resp` bit 5 is set together with bit 0.
- R6: If the summed lengths exceed the total, `resp` bit 6 is set together with bit 0. This does not apply when flag bit 1 (discard excess) is set on the last entry; then bit 6 stays clear.
- R7: A length field of 0 aborts the walk with `resp` = 0x80 and issues no transfer for that descriptor.
- R8: A length above `MAX_SEG` (default 65024) aborts the walk with `resp` = 0x80 and issues no transfer for that descriptor. A length equal to `MAX_SEG` is accepted.
- R9: When `MAX_DESC` transfers have completed without any entry carrying the last flag, the walk ends with `resp` = 0x80 and no further read.
- R10: A command-packet entry (flag bit 2, normally with bit 5) is issued as a transfer, and its length counts in the sum.
- R11: A `start` pulse while `busy` is high is ignored: the pointer and total of the walk in progress are kept.
- R12: After reset, `busy`, `done`, `mem_rd_req` and `xfer_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a walk |
| first_ptr | input | 32 | Byte address of the first descriptor |
| total_len | input | 32 | Expected total byte count |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk strobe |
| resp | output | 8 | Response byte: bit0 complete, bit5 under, bit6 over, bit7 error |
| mem_rd_req | output | 1 | Read request pulse |
| mem_rd_addr | output | 32 | Read byte address, valid with `mem_rd_req` |
| mem_rd_valid | input | 1 | Read data returned, at least one cycle after the request |
| mem_rd_data | input | 32 | Read data word |
| xfer_valid | output | 1 | Transfer request pending |
| xfer_addr | output | 32 | Region address |
| xfer_len | output | 16 | Region length in bytes |
| xfer_write | output | 1 | Direction: 1 = toward the device |
| xfer_flags | output | 8 | Raw descriptor flag byte |
| xfer_done | input | 1 | Data mover finished the request |

## Verification
The bench builds the walker with `MAX_DESC` = 4 and keeps `MAX_SEG` at its default of 65024. The small budget brings the chain-overrun abort within reach after four transfers. The default limit lets the bench place lengths of 65024 and 65025 directly on both sides of the segment boundary. Chains of one to three entries cover exact, short and excess totals, the discard-excess exemption, a leading command-packet entry and aborts partway through a chain.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

  localparam int ADDR_W     = 32;
  localparam int DESC_LEN_W = 16;

  // flag byte bit positions (decoded by the data mover as well)
  localparam int FLG_DRAIN = 1;
  localparam int FLG_CMD   = 2;
  localparam int FLG_WRITE = 5;
  localparam int FLG_LAST  = 7;

  // response byte bit positions
  localparam int RSP_DONE  = 0;
  localparam int RSP_UNDER = 5;
  localparam int RSP_OVER  = 6;
  localparam int RSP_ERR   = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_A,
    ST_WAIT_A,
    ST_REQ_B,
    ST_WAIT_B,
    ST_CHECK,
    ST_XFER,
    ST_END
  } walk_state_t;

  // a length is usable when nonzero and within the segment limit
  function automatic logic seg_len_ok(input logic [DESC_LEN_W-1:0] len,
                                      input logic [DESC_LEN_W:0]   lim);
    return (len != '0) && ({1'b0, len} <= lim);
  endfunction

  // response of a walk that reached the last-entry flag
  function automatic logic [7:0] close_resp(input logic [ADDR_W-1:0] sum,
                                            input logic [ADDR_W-1:0] total,
                                            input logic              drain);
    logic [7:0] r;
    r            = '0;
    r[RSP_DONE]  = 1'b1;
    r[RSP_UNDER] = (sum < total);
    r[RSP_OVER]  = (sum > total) && !drain;
    return r;
  endfunction

  function automatic logic [7:0] error_resp();
    logic [7:0] r;
    r          = '0;
    r[RSP_ERR] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/sgw_desc_unpack.sv
module sgw_desc_unpack
  import sgw_pkg::*;
#(
  parameter int MAX_SEG = 65024
) (
  input  logic [23:0]           word_b,   // {flags, len}
  output logic [DESC_LEN_W-1:0] len,
  output logic [7:0]            flags,
  output logic                  is_last,
  output logic                  is_drain,
  output logic                  is_write,
  output logic                  seg_ok
);
  localparam logic [DESC_LEN_W:0] SEG_LIM = (DESC_LEN_W+1)'(MAX_SEG);

  assign len      = word_b[DESC_LEN_W-1:0];
  assign flags    = word_b[23:16];
  assign is_last  = flags[FLG_LAST];
  assign is_drain = flags[FLG_DRAIN];
  assign is_write = flags[FLG_WRITE];
  assign seg_ok   = seg_len_ok(len, SEG_LIM);
endmodule

// File: rtl/sgw_tally.sv
module sgw_tally
  import sgw_pkg::*;
#(
  parameter int MAX_DESC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  add,
  input  logic [DESC_LEN_W-1:0] add_len,
  output logic [ADDR_W-1:0]     sum,
  output logic                  last_slot
);
  localparam int CNT_W = $clog2(MAX_DESC + 1);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum   <= '0;
      count <= '0;
    end else if (clear) begin
      sum   <= '0;
      count <= '0;
    end else if (add) begin
      sum   <= sum + ADDR_W'(add_len);
      count <= count + 1'b1;
    end
  end

  assign last_slot = (count == CNT_W'(MAX_DESC - 1));

  // R9: the budget is never exceeded
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_DESC));
endmodule

// File: rtl/sgw_seq.sv
module sgw_seq
  import sgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_ptr,
  input  logic [ADDR_W-1:0] total_len,
  output logic              busy,
  output logic              done,
  output logic [7:0]        resp,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [31:0]       mem_rd_data,
  output logic [23:0]       word_b,
  input  logic              d_last,
  input  logic              d_drain,
  input  logic              d_seg_ok,
  output logic              tally_clear,
  output logic              tally_add,
  input  logic [ADDR_W-1:0] sum,
  input  logic              last_slot,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  input  logic              xfer_done
);
  walk_state_t       st;
  logic [ADDR_W-1:0] ptr_q, addr_q, total_q;
  logic              done_q;
  logic [7:0]        resp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ptr_q   <= '0;
      addr_q  <= '0;
      total_q <= '0;
      word_b  <= '0;
      done_q  <= 1'b0;
      resp_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          ptr_q   <= first_ptr;
          total_q <= total_len;
          st      <= ST_REQ_A;
        end
        ST_REQ_A: st <= ST_WAIT_A;
        ST_WAIT_A: if (mem_rd_valid) begin
          addr_q <= mem_rd_data;
          st     <= ST_REQ_B;
        end
        ST_REQ_B: st <= ST_WAIT_B;
        ST_WAIT_B: if (mem_rd_valid) begin
          word_b <= {mem_rd_data[31:24], mem_rd_data[15:0]};
          st     <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!d_seg_ok) begin
            done_q <= 1'b1;
            resp_q <= error_resp();
            st     <= ST_IDLE;
          end else begin
            st <= ST_XFER;
          end
        end
        ST_XFER: if (xfer_done) begin
          if (d_last) begin
            st <= ST_END;
          end else if (last_slot) begin
            done_q <= 1'b1;
            resp_q <= error_resp();
            st     <= ST_IDLE;
          end else begin
            ptr_q <= ptr_q + ADDR_W'(8);
            st    <= ST_REQ_A;
          end
        end
        ST_END: begin
          done_q <= 1'b1;
          resp_q <= close_resp(sum, total_q, d_drain);
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (st != ST_IDLE);
  assign done        = done_q;
  assign resp        = resp_q;
  assign mem_rd_req  = (st == ST_REQ_A) || (st == ST_REQ_B);
  assign mem_rd_addr = (st == ST_REQ_B) ? ptr_q + ADDR_W'(4) : ptr_q;
  assign tally_clear = (st == ST_IDLE) && start;
  assign tally_add   = (st == ST_XFER) && xfer_done;
  assign xfer_valid  = (st == ST_XFER);
  assign xfer_addr   = addr_q;

  // R1: one read outstanding, request is a pulse
  a_r1_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);
  // R3: request held steady until the mover answers
  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_done |=> xfer_valid && $stable(addr_q) && $stable(word_b));
  // R4: end strobe lasts one cycle and leaves the block idle
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5/R6: short and excess never reported together
  a_r6_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(resp[RSP_UNDER] && resp[RSP_OVER]));
  // R11: a start during a walk keeps the expected total
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(total_q));
endmodule

// File: rtl/sgw_walker.sv
module sgw_walker
  import sgw_pkg::*;
#(
  parameter int MAX_DESC = 64,
  parameter int MAX_SEG  = 65024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] first_ptr,
  input  logic [31:0] total_len,
  output logic        busy,
  output logic        done,
  output logic [7:0]  resp,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        xfer_valid,
  output logic [31:0] xfer_addr,
  output logic [15:0] xfer_len,
  output logic        xfer_write,
  output logic [7:0]  xfer_flags,
  input  logic        xfer_done
);
  logic [23:0]           word_b;
  logic [DESC_LEN_W-1:0] d_len;
  logic [7:0]            d_flags;
  logic                  d_last, d_drain, d_write, d_seg_ok;
  logic                  tally_clear, tally_add, last_slot;
  logic [ADDR_W-1:0]     sum;

  sgw_desc_unpack #(.MAX_SEG(MAX_SEG)) u_unpack (
    .word_b  (word_b),
    .len     (d_len),
    .flags   (d_flags),
    .is_last (d_last),
    .is_drain(d_drain),
    .is_write(d_write),
    .seg_ok  (d_seg_ok)
  );

  sgw_tally #(.MAX_DESC(MAX_DESC)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (tally_clear),
    .add      (tally_add),
    .add_len  (d_len),
    .sum      (sum),
    .last_slot(last_slot)
  );

  sgw_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .first_ptr   (first_ptr),
    .total_len   (total_len),
    .busy        (busy),
    .done        (done),
    .resp        (resp),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_data (mem_rd_data),
    .word_b      (word_b),
    .d_last      (d_last),
    .d_drain     (d_drain),
    .d_seg_ok    (d_seg_ok),
    .tally_clear (tally_clear),
    .tally_add   (tally_add),
    .sum         (sum),
    .last_slot   (last_slot),
    .xfer_valid  (xfer_valid),
    .xfer_addr   (xfer_addr),
    .xfer_done   (xfer_done)
  );

  assign xfer_len   = d_len;
  assign xfer_flags = d_flags;
  assign xfer_write = d_write;

  // R7: a zero length never reaches the mover
  a_r7_nonzero_len: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_len != '0);
  // R8: no segment above the limit reaches the mover
  a_r8_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> {1'b0, xfer_len} <= 17'(MAX_SEG));
endmodule

// File: tb/sgw_walker_bench.sv
`timescale 1ns/1ps
module sgw_walker_bench;
  localparam int MAXD = 4;
  localparam int SEGL = 65024;
  localparam logic [31:0] BASE = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] first_ptr = '0, total_len = '0;
  logic        busy, done;
  logic [7:0]  resp;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        xfer_valid, xfer_write;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_len;
  logic [7:0]  xfer_flags;
  logic        xfer_done = 1'b0;

  integer errors = 0, checks = 0;

  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:31];
  integer      rd_n = 0;
  logic [31:0] xa_log [0:15];
  logic [15:0] xl_log [0:15];
  logic [7:0]  xf_log [0:15];
  logic        xw_log [0:15];
  integer      x_n = 0;
  integer      r3_viol = 0;

  sgw_walker #(.MAX_DESC(MAXD), .MAX_SEG(SEGL)) u_sgw_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .first_ptr(first_ptr),
    .total_len(total_len), .busy(busy), .done(done), .resp(resp),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_write(xfer_write), .xfer_flags(xfer_flags), .xfer_done(xfer_done)
  );

  initial forever #2.5 clk = ~clk;

  // memory model: request seen at a falling edge, data one cycle later
  initial begin
    logic        pend;
    logic [31:0] pa;
    pend = 1'b0;
    pa   = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_valid) mem_rd_valid = 1'b0;
      if (pend) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem[pa[9:2]];
        pend = 1'b0;
      end
      if (mem_rd_req) begin
        pend = 1'b1;
        pa   = mem_rd_addr;
        if (rd_n < 32) rd_log[rd_n] = mem_rd_addr;
        rd_n = rd_n + 1;
      end
    end
  end

  // data mover model: answers after three cycles, watches request stability
  initial begin
    integer      xw;
    logic [31:0] sa;
    logic [15:0] sl;
    logic [7:0]  sf;
    xw = 0; sa = '0; sl = '0; sf = '0;
    forever begin
      @(negedge clk);
      if (xfer_valid && mem_rd_req) r3_viol = r3_viol + 1;
      if (xfer_done) begin
        xfer_done = 1'b0;
      end else if (xfer_valid) begin
        if (xw == 0) begin
          sa = xfer_addr; sl = xfer_len; sf = xfer_flags;
          if (x_n < 16) begin
            xa_log[x_n] = xfer_addr; xl_log[x_n] = xfer_len;
            xf_log[x_n] = xfer_flags; xw_log[x_n] = xfer_write;
          end
          x_n = x_n + 1;
        end else if (xfer_addr != sa || xfer_len != sl || xfer_flags != sf) begin
          r3_viol = r3_viol + 1;
        end
        xw = xw + 1;
        if (xw == 3) begin
          xfer_done = 1'b1;
          xw = 0;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic put_desc(input int idx, input logic [31:0] a,
                          input logic [15:0] l, input logic [7:0] f);
    mem[(BASE >> 2) + 2*idx]     = a;
    mem[(BASE >> 2) + 2*idx + 1] = {f, 8'h00, l};
  endtask

  // pulse start, then wait for the end strobe; returns the response byte
  task automatic run_walk(input logic [31:0] ptr, input logic [31:0] tot,
                          output logic [7:0] r, output logic seen);
    rd_n = 0; x_n = 0; seen = 1'b0; r = '0;
    @(negedge clk);
    first_ptr = ptr; total_len = tot; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      if (done) begin
        seen = 1'b1;
        r = resp;
        chk(!busy, "R4 busy low at done", 32'(busy), 32'd0);
      end else begin
        @(negedge clk);
      end
    end
    chk(seen, "R4 walk finished", 32'(seen), 32'd1);
  endtask

  // case table: {count, len0, len1, len2, cmd-first, drain-last, total, resp}
  localparam int NV = 9;
  localparam logic [93:0] TAB [0:NV-1] = '{
    {4'd1, 16'd512,   16'd0,     16'd0,   1'b0, 1'b0, 32'd512,   8'h01},
    {4'd3, 16'd100,   16'd200,   16'd300, 1'b0, 1'b0, 32'd600,   8'h01},
    {4'd2, 16'd100,   16'd200,   16'd0,   1'b0, 1'b0, 32'd400,   8'h21},
    {4'd2, 16'd100,   16'd200,   16'd0,   1'b0, 1'b0, 32'd250,   8'h41},
    {4'd2, 16'd100,   16'd200,   16'd0,   1'b0, 1'b1, 32'd250,   8'h01},
    {4'd2, 16'd12,    16'd500,   16'd0,   1'b1, 1'b0, 32'd512,   8'h01},
    {4'd1, 16'd65024, 16'd0,     16'd0,   1'b0, 1'b0, 32'd65024, 8'h01},
    {4'd2, 16'd0,     16'd64,    16'd0,   1'b0, 1'b0, 32'd64,    8'h80},
    {4'd2, 16'd100,   16'd65025, 16'd0,   1'b0, 1'b0, 32'd65125, 8'h80}
  };

  function automatic string case_tag(input int k);
    case (k)
      2: return "R5";
      3: return "R6";
      4: return "R6 drain";
      5: return "R10";
      6: return "R8 boundary";
      7: return "R7";
      8: return "R8";
      default: return "R4";
    endcase
  endfunction

  initial begin
    logic [7:0] r;
    logic       seen;
    repeat (150000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL R4 watchdog: act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic        seen;
    logic [15:0] lens [0:2];
    logic [7:0]  fl;
    integer      nexp;
    for (int i = 0; i < 256; i++) mem[i] = '0;

    repeat (3) @(negedge clk);
    // R12: quiet outputs while and after reset
    chk(!busy && !done && !mem_rd_req && !xfer_valid, "R12 reset outputs",
        {28'd0, busy, done, mem_rd_req, xfer_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_rd_req && !xfer_valid, "R12 after release",
        {28'd0, busy, done, mem_rd_req, xfer_valid}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      logic [93:0] t;
      int          n;
      t = TAB[k];
      n = int'(t[93:90]);
      lens[0] = t[89:74]; lens[1] = t[73:58]; lens[2] = t[57:42];
      for (int i = 0; i < n; i++) begin
        fl = (k % 2 == 1) ? 8'h10 : 8'h20;
        if (i == 0 && t[41]) fl = 8'h24;
        if (i == n - 1) fl = fl | 8'h80 | (t[40] ? 8'h02 : 8'h00);
        put_desc(i, 32'h1000_0000 + 32'(i) * 32'h100 + 32'(k), lens[i], fl);
      end
      nexp = 0;
      for (int i = 0; i < n; i++) begin
        if (lens[i] == 16'd0 || lens[i] > 16'(SEGL)) break;
        nexp = nexp + 1;
      end
      run_walk(BASE, t[39:8], r, seen);
      chk(r == t[7:0], {case_tag(k), " response"}, 32'(r), 32'(t[7:0]));
      chk(x_n == nexp, {case_tag(k), " R2 transfer count"}, 32'(x_n), 32'(nexp));
      for (int i = 0; i < nexp && i < 16; i++) begin
        fl = (k % 2 == 1) ? 8'h10 : 8'h20;
        if (i == 0 && t[41]) fl = 8'h24;
        if (i == n - 1) fl = fl | 8'h80 | (t[40] ? 8'h02 : 8'h00);
        chk(xa_log[i] == 32'h1000_0000 + 32'(i) * 32'h100 + 32'(k), "R2 address",
            xa_log[i], 32'h1000_0000 + 32'(i) * 32'h100 + 32'(k));
        chk(xl_log[i] == lens[i], "R2 length", 32'(xl_log[i]), 32'(lens[i]));
        chk(xf_log[i] == fl, "R2 flags", 32'(xf_log[i]), 32'(fl));
        chk(xw_log[i] == fl[5], "R2 direction", 32'(xw_log[i]), 32'(fl[5]));
      end
      chk(rd_log[0] == BASE && rd_log[1] == BASE + 4, "R1 first reads",
          rd_log[1], BASE + 4);
      if (n > 1 && nexp > 0)
        chk(rd_log[2] == BASE + 8, "R1 next descriptor", rd_log[2], BASE + 8);
    end

    // R9: four entries, none marked last
    for (int i = 0; i < 4; i++) put_desc(i, 32'h2000_0000 + 32'(i), 16'd10, 8'h10);
    run_walk(BASE, 32'd40, r, seen);
    chk(r == 8'h80, "R9 budget response", 32'(r), 32'h80);
    chk(x_n == 4, "R9 transfer count", 32'(x_n), 32'd4);
    chk(rd_n == 8, "R9 no read past budget", 32'(rd_n), 32'd8);

    // R11: start during a walk is ignored
    put_desc(0, 32'h3000_0000, 16'd100, 8'h20);
    put_desc(1, 32'h3000_0100, 16'd50,  8'hA0);
    rd_n = 0; x_n = 0; seen = 1'b0; r = '0;
    @(negedge clk);
    first_ptr = BASE; total_len = 32'd150; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    first_ptr = 32'h200; total_len = 32'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      if (done) begin seen = 1'b1; r = resp; end
      else @(negedge clk);
    end
    chk(r == 8'h01, "R11 total kept", 32'(r), 32'h01);
    chk(rd_n == 4 && rd_log[2] == BASE + 8, "R11 pointer kept", rd_log[2], BASE + 8);

    // R3: stability and read silence observed across every transfer above
    chk(r3_viol == 0, "R3 request held", 32'(r3_viol), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule